// File: doc/BRIEF.md
# Shared Shift-Add Constant Multiplier Bank

This block multiplies one signed sample by four fixed constants (7, 13, 14 and 57) using no hardware multipliers. Each product is built from shifted copies of the input added or subtracted together. The 7 and 13 products share one intermediate sum, five times the input. The 14 and 57 products use signed-digit recoding, which replaces runs of additions with one subtraction.

One sample arrives per cycle with a valid flag. The four products are registered together on one edge and come out one cycle later. The valid flag is delayed along with them. The outputs are wide enough that no product can overflow. A bank like this drives the taps of a transposed-form filter, where a single sample feeds many coefficient products at once.

Top module: `mcm_shift_add`

## Requirements
- R1: While reset (synchronous, active high) is high at a clock edge, every product output and outValid become zero after that edge.
- R2: outValid equals inValid sampled at the previous rising clock edge.
- R3: prod7 equals 7 times the input sampled one cycle earlier, as a two's-complement value of width DATA_W+7.
- R4: prod13 equals 13 times the input sampled one cycle earlier.
- R5: prod14 equals 14 times the input sampled one cycle earlier.
- R6: prod57 equals 57 times the input sampled one cycle earlier.
- R7: No product overflows for any input, including the most negative (-32768) and most positive (32767) 16-bit values.
- R8: The product registers load on every clock edge that is not under reset, whatever the state of inValid. Data presented with inValid low still appears on the products one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample qualifier |
| sampleIn | input | DATA_W (16) | Signed input sample |
| outValid | output | 1 | Qualifier for the registered products |
| prod7 | output | DATA_W+7 | 7 × sample |
| prod13 | output | DATA_W+7 | 13 × sample |
| prod14 | output | DATA_W+7 | 14 × sample |
| prod57 | output | DATA_W+7 | 57 × sample |

## Verification
A fault in the shared five-times term affects prod7 and prod13 together on the very next cycle. A wrong shift or sign in a signed-digit path shows up as a miscompare on that one product only. Sign-extension faults stay hidden for small positive inputs. They appear only when the input is negative or near full scale, so those extreme values are driven explicitly. A stuck or mistimed valid register shows as outValid out of step with inValid by one cycle.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int DATA_W = 16;
  localparam int GROW_W = 7;
  localparam int PROD_W = DATA_W + GROW_W;

  typedef struct packed {
    logic clear;
    logic load;
  } mcmCtrl_t;
endpackage

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output mcmCtrl_t ctrl,
  output logic     outValid
);
  always_comb begin
    ctrl.clear = rst;
    ctrl.load  = !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/mcm_datapath.sv
module mcm_datapath
  import mcm_pkg::*;
#(
  parameter int IN_W  = DATA_W,
  parameter int OUT_W = IN_W + GROW_W
)(
  input  logic                    clk,
  input  mcmCtrl_t                ctrl,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [OUT_W-1:0] prod7,
  output logic signed [OUT_W-1:0] prod13,
  output logic signed [OUT_W-1:0] prod14,
  output logic signed [OUT_W-1:0] prod57
);
  logic signed [OUT_W-1:0] xWide;
  logic signed [OUT_W-1:0] fiveX;
  logic signed [OUT_W-1:0] sum7, sum13, sum14, sum57;

  always_comb begin
    xWide = OUT_W'(sampleIn);
    fiveX = xWide + (xWide <<< 2);
    sum7  = fiveX + (xWide <<< 1);
    sum13 = fiveX + (xWide <<< 3);
    sum14 = (xWide <<< 4) - (xWide <<< 1);
    sum57 = (xWide <<< 6) - (xWide <<< 3) + xWide;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      prod7  <= '0;
      prod13 <= '0;
      prod14 <= '0;
      prod57 <= '0;
    end else if (ctrl.load) begin
      prod7  <= sum7;
      prod13 <= sum13;
      prod14 <= sum14;
      prod57 <= sum57;
    end
  end
endmodule

// File: rtl/mcm_shift_add.sv
module mcm_shift_add
  import mcm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic                     outValid,
  output logic signed [PROD_W-1:0] prod7,
  output logic signed [PROD_W-1:0] prod13,
  output logic signed [PROD_W-1:0] prod14,
  output logic signed [PROD_W-1:0] prod57
);
  mcmCtrl_t ctrl;

  mcm_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  mcm_datapath #(.IN_W(DATA_W)) uData (
    .clk(clk), .ctrl(ctrl), .sampleIn(sampleIn),
    .prod7(prod7), .prod13(prod13), .prod14(prod14), .prod57(prod57)
  );
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker
  import mcm_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] sampleIn,
  input logic                     outValid,
  input logic signed [PROD_W-1:0] prod7,
  input logic signed [PROD_W-1:0] prod13,
  input logic signed [PROD_W-1:0] prod14,
  input logic signed [PROD_W-1:0] prod57
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (outValid == 1'b0 && prod7 == '0 && prod13 == '0 && prod14 == '0 && prod57 == '0));

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> outValid == $past(inValid));

  a_r3_prod7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod7 == PROD_W'(7 * $past(PROD_W'(sampleIn))));

  a_r4_prod13: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod13 == PROD_W'(13 * $past(PROD_W'(sampleIn))));

  a_r5_prod14: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod14 == PROD_W'(14 * $past(PROD_W'(sampleIn))));

  a_r6_prod57: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod57 == PROD_W'(57 * $past(PROD_W'(sampleIn))));

  a_r7_sign_consistent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sampleIn) != '0) |->
      (prod57[PROD_W-1] == $past(sampleIn[DATA_W-1]) && prod7[PROD_W-1] == $past(sampleIn[DATA_W-1])));

  a_r8_load_without_valid: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> prod14 == PROD_W'(14 * $past(PROD_W'(sampleIn))));
endmodule

bind mcm_shift_add mcm_checker uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .sampleIn(sampleIn), .outValid(outValid),
  .prod7(prod7), .prod13(prod13), .prod14(prod14), .prod57(prod57)
);

// File: tb/tb_mcm_shift_add.sv
`timescale 1ns/1ps
module tb_mcm_shift_add;
  import mcm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] sampleIn = '0;
  logic outValid;
  logic signed [PROD_W-1:0] prod7, prod13, prod14, prod57;

  always #2 clk = ~clk;

  mcm_shift_add dut (.*);

  typedef struct {
    logic                     v;
    logic signed [PROD_W-1:0] e7, e13, e14, e57;
    string                    tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit driveDone = 0;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic signed [DATA_W-1:0] x, logic v, string tag);
    expItem_t it;
    longint xl;
    xl = longint'(x);
    it.v = v;
    it.e7 = PROD_W'(7 * xl);
    it.e13 = PROD_W'(13 * xl);
    it.e14 = PROD_W'(14 * xl);
    it.e57 = PROD_W'(57 * xl);
    it.tag = tag;
    @(negedge clk);
    sampleIn = x;
    inValid = v;
    expQ.push_back(it);
  endtask

  // monitor: the registered result for the item driven before edge N is visible after edge N
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && expQ.size() > 0) begin
        it = expQ.pop_front();
        check({"R2 valid ", it.tag}, longint'(outValid), longint'(it.v));
        check({"R3 prod7 ", it.tag}, longint'(prod7), longint'(it.e7));
        check({"R4 prod13 ", it.tag}, longint'(prod13), longint'(it.e13));
        check({"R5 prod14 ", it.tag}, longint'(prod14), longint'(it.e14));
        check({"R6 prod57 ", it.tag}, longint'(prod57), longint'(it.e57));
      end
    end
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 outValid", longint'(outValid), 0);
    check("R1 prod7", longint'(prod7), 0);
    check("R1 prod57", longint'(prod57), 0);
    @(negedge clk);
    rst = 1'b0;
    drive(16'sd1, 1'b1, "one");
    drive(-16'sd1, 1'b1, "minus one");
    drive(16'sh7FFF, 1'b1, "R7 max");
    drive(16'sh8000, 1'b1, "R7 min");
    drive(16'sd1234, 1'b0, "R8 invalid");
    drive(-16'sd999, 1'b0, "R8 invalid neg");
    for (int i = 0; i < 200; i++)
      drive(DATA_W'($urandom), 1'($urandom), "random");
    drive(16'sh8000, 1'b1, "R7 min again");
    @(negedge clk);
    sampleIn = 16'sd77;
    inValid = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    expQ.delete();
    check("R1 reset mid-stream valid", longint'(outValid), 0);
    check("R1 reset mid-stream prod13", longint'(prod13), 0);
    check("R1 reset mid-stream prod14", longint'(prod14), 0);
    repeat (2) @(posedge clk);
    driveDone = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule